// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block prepares the second operand of an integer ALU in a single combinational pass. A 32-bit operand is shifted left or right, shifted right with sign fill, or rotated. The amount comes either from a 5-bit field held in the instruction or from the low byte of a register. The block returns the shifted value and a carry-out that the flag logic can latch when the instruction asks for flag updates. Register reads, the ALU itself and flag writeback sit outside the block.

When the amount is an immediate field, a zero amount is reinterpreted according to the shift kind. The same block also builds rotated immediates: an 8-bit constant, zero-extended and rotated right by twice a 4-bit field. When that form is selected it replaces the shifter output. The design has no clock. It decodes the amount, runs one shifter core and muxes the result, and all of these paths are pure logic.

Top module: `opshift_unit`

## Requirements
- R1: With `kind_i` = 0 (shift left) and an amount n of 1..31, `result_o` is the operand moved up n places with zeros entering at bit 0, and `carry_o` is operand bit 32−n.
- R2: With `kind_i` = 1 (logical right) and an amount n of 1..31, `result_o` has zeros entering at bit 31, and `carry_o` is operand bit n−1.
- R3: With `kind_i` = 2 (arithmetic right) and an amount n of 1..31, vacated upper bits copy operand bit 31, and `carry_o` is operand bit n−1.
- R4: With `kind_i` = 3 (rotate right) and an amount n of 1..31, bit i of the result is operand bit (i+n) mod 32, and `carry_o` is result bit 31.
- R5: In immediate mode (`src_reg_i` = 0), a left shift by 0 returns the operand unchanged and `carry_o` equals `carry_i`.
- R6: In immediate mode, a logical right shift by 0 acts as a shift by 32: the result is zero and `carry_o` is operand bit 31.
- R7: In immediate mode, an arithmetic right shift by 0 acts as a shift by 32: every result bit and `carry_o` equal operand bit 31.
- R8: In immediate mode, a rotate by 0 is a one-place rotate through carry: the result is {`carry_i`, operand[31:1]} and `carry_o` is operand bit 0.
- R9: In register mode (`src_reg_i` = 1), only bits 7:0 of `reg_amt_i` set the amount, and bits 31:8 have no effect on either output.
- R10: In register mode, an amount byte of zero leaves the operand and the carry unchanged for every shift kind.
- R11: In register mode, a left or logical right shift by exactly 32 gives zero with carry equal to operand bit 0 (left) or operand bit 31 (right). Amounts above 32 give zero with carry 0.
- R12: In register mode, an arithmetic right shift by 32 or more fills the result and the carry with operand bit 31. A rotate uses the amount modulo 32, and a nonzero multiple of 32 returns the operand with carry equal to operand bit 31.
- R13: With `rimm_sel_i` = 1, `result_o` is `rimm_val_i` zero-extended to 32 bits and rotated right by 2×`rimm_rot_i`. The shifter inputs have no effect in this form.
- R14: With `rimm_sel_i` = 1, `carry_o` equals `carry_i` when `rimm_rot_i` is 0, and equals bit 31 of the rotated result otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_i | input | 32 | Operand to be shifted |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| src_reg_i | input | 1 | Amount source: 0 immediate field, 1 register low byte |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 32 | Register holding the shift amount (low byte used) |
| carry_i | input | 1 | Current carry flag |
| rimm_sel_i | input | 1 | Select the rotated-immediate form |
| rimm_val_i | input | 8 | 8-bit immediate constant |
| rimm_rot_i | input | 4 | Rotate field; the rotate amount is twice this value |
| result_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench sweeps every immediate amount for all four kinds over operands with distinct edge bits. An error in the zero-amount reinterpretation would show up as a pass-through where a full shift, a sign fill or a rotate through carry belongs. Register amounts go after the boundary at 32, amounts above 32, large bytes and multiples of 32 for rotate. A design that wraps these amounts modulo 32, or takes the carry from the wrong end, would return a nonzero value or a wrong carry there. Junk in the upper register bits would show up in the result if any of those bits leaked into the amount. All sixteen rotations of the immediate form are checked with both carry inputs, which catches a rotate by the raw field or a carry that is recomputed when the rotate is zero.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    // Shift kind as carried on kind_i
    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    // Canonical operation handed from the amount decoder to the core
    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_LSL  = 3'd1,
        OP_LSR  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RRX  = 3'd5
    } core_op_e;

endpackage

// File: rtl/opshift_amt_dec.sv
module opshift_amt_dec
    import opshift_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RBW = 8
) (
    input  shift_kind_e         kind_i,
    input  logic                src_reg_i,
    input  logic [$clog2(DW)-1:0] imm_amt_i,
    input  logic [DW-1:0]       reg_amt_i,
    output core_op_e            op_o,
    output logic [$clog2(DW):0] amt_o
);
    localparam int AW = $clog2(DW);
    localparam logic [AW:0]    FULL_A = (AW+1)'(DW);
    localparam logic [AW:0]    OVER_A = (AW+1)'(DW + 1);
    localparam logic [RBW-1:0] FULL_B = RBW'(DW);

    logic [RBW-1:0] rbyte;
    assign rbyte = reg_amt_i[RBW-1:0];

    core_op_e    kind_op;
    always_comb begin
        unique case (kind_i)
            SK_LSL:  kind_op = OP_LSL;
            SK_LSR:  kind_op = OP_LSR;
            SK_ASR:  kind_op = OP_ASR;
            default: kind_op = OP_ROR;
        endcase
    end

    always_comb begin
        op_o  = kind_op;
        amt_o = '0;
        if (!src_reg_i) begin
            if (imm_amt_i == '0) begin
                unique case (kind_i)
                    SK_LSL:  op_o = OP_PASS;
                    SK_LSR:  amt_o = FULL_A;
                    SK_ASR:  amt_o = FULL_A;
                    default: op_o = OP_RRX;
                endcase
            end else begin
                amt_o = {1'b0, imm_amt_i};
            end
        end else if (rbyte == '0) begin
            op_o = OP_PASS;
        end else begin
            unique case (kind_i)
                SK_LSL, SK_LSR:
                    amt_o = (rbyte > FULL_B) ? OVER_A : (AW+1)'(rbyte);
                SK_ASR:
                    amt_o = (rbyte >= FULL_B) ? FULL_A : (AW+1)'(rbyte);
                default:
                    amt_o = (rbyte[AW-1:0] == '0) ? FULL_A : {1'b0, rbyte[AW-1:0]};
            endcase
        end
    end
endmodule

// File: rtl/opshift_core.sv
module opshift_core
    import opshift_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]       opd_i,
    input  core_op_e            op_i,
    input  logic [$clog2(DW):0] amt_i,
    input  logic                carry_i,
    output logic [DW-1:0]       res_o,
    output logic                carry_o
);
    // Each path keeps one guard bit next to the result so the last bit
    // moved out falls into a fixed position.
    logic [2*DW:0]          wide_l;
    logic [2*DW+1:0]        wide_r;
    logic signed [2*DW+1:0] wide_a;
    logic [2*DW-1:0]        wide_o;

    always_comb begin
        wide_l = {{DW{1'b0}}, 1'b0, opd_i} << amt_i;
        wide_r = {{(DW+1){1'b0}}, opd_i, 1'b0} >> amt_i;
        wide_a = $signed({{(DW+1){opd_i[DW-1]}}, opd_i, 1'b0}) >>> amt_i;
        wide_o = {opd_i, opd_i} >> amt_i;
    end

    always_comb begin
        unique case (op_i)
            OP_LSL: begin
                res_o   = wide_l[DW-1:0];
                carry_o = wide_l[DW];
            end
            OP_LSR: begin
                res_o   = wide_r[DW:1];
                carry_o = wide_r[0];
            end
            OP_ASR: begin
                res_o   = wide_a[DW:1];
                carry_o = wide_a[0];
            end
            OP_ROR: begin
                res_o   = wide_o[DW-1:0];
                carry_o = wide_o[DW-1];
            end
            OP_RRX: begin
                res_o   = {carry_i, opd_i[DW-1:1]};
                carry_o = opd_i[0];
            end
            default: begin
                res_o   = opd_i;
                carry_o = carry_i;
            end
        endcase
    end
endmodule

// File: rtl/opshift_rimm.sv
module opshift_rimm #(
    parameter int DW  = 32,
    parameter int IMW = 8,
    parameter int RFW = 4
) (
    input  logic [IMW-1:0] val_i,
    input  logic [RFW-1:0] rot_i,
    input  logic           carry_i,
    output logic [DW-1:0]  res_o,
    output logic           carry_o
);
    localparam int RAW = RFW + 1;

    logic [RAW-1:0]   rot_amt;
    logic [DW-1:0]    zext;
    logic [2*DW-1:0]  doubled;

    always_comb begin
        rot_amt = {rot_i, 1'b0};
        zext    = {{(DW-IMW){1'b0}}, val_i};
        doubled = {zext, zext} >> rot_amt;
        res_o   = doubled[DW-1:0];
        carry_o = (rot_i == '0) ? carry_i : doubled[DW-1];
    end
endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RBW = 8,
    parameter int IMW = 8,
    parameter int RFW = 4
) (
    input  logic [DW-1:0]         opd_i,
    input  logic [1:0]            kind_i,
    input  logic                  src_reg_i,
    input  logic [$clog2(DW)-1:0] imm_amt_i,
    input  logic [DW-1:0]         reg_amt_i,
    input  logic                  carry_i,
    input  logic                  rimm_sel_i,
    input  logic [IMW-1:0]        rimm_val_i,
    input  logic [RFW-1:0]        rimm_rot_i,
    output logic [DW-1:0]         result_o,
    output logic                  carry_o
);
    localparam int AW = $clog2(DW);

    core_op_e    dec_op;
    logic [AW:0] dec_amt;
    logic [DW-1:0] sh_res;
    logic          sh_c;
    logic [DW-1:0] ri_res;
    logic          ri_c;

    opshift_amt_dec #(.DW(DW), .RBW(RBW)) u_dec (
        .kind_i    (shift_kind_e'(kind_i)),
        .src_reg_i (src_reg_i),
        .imm_amt_i (imm_amt_i),
        .reg_amt_i (reg_amt_i),
        .op_o      (dec_op),
        .amt_o     (dec_amt)
    );

    opshift_core #(.DW(DW)) u_core (
        .opd_i   (opd_i),
        .op_i    (dec_op),
        .amt_i   (dec_amt),
        .carry_i (carry_i),
        .res_o   (sh_res),
        .carry_o (sh_c)
    );

    opshift_rimm #(.DW(DW), .IMW(IMW), .RFW(RFW)) u_rimm (
        .val_i   (rimm_val_i),
        .rot_i   (rimm_rot_i),
        .carry_i (carry_i),
        .res_o   (ri_res),
        .carry_o (ri_c)
    );

    always_comb begin
        if (rimm_sel_i) begin
            result_o = ri_res;
            carry_o  = ri_c;
        end else begin
            result_o = sh_res;
            carry_o  = sh_c;
        end
    end
endmodule

// File: rtl/opshift_unit_chk.sv
module opshift_unit_chk #(
    parameter int DW  = 32,
    parameter int IMW = 8,
    parameter int RFW = 4
) (
    input logic [DW-1:0]         opd_i,
    input logic [1:0]            kind_i,
    input logic                  src_reg_i,
    input logic [$clog2(DW)-1:0] imm_amt_i,
    input logic [DW-1:0]         reg_amt_i,
    input logic                  carry_i,
    input logic                  rimm_sel_i,
    input logic [IMW-1:0]        rimm_val_i,
    input logic [RFW-1:0]        rimm_rot_i,
    input logic [DW-1:0]         result_o,
    input logic                  carry_o
);
    logic known;
    assign known = !$isunknown({opd_i, kind_i, src_reg_i, imm_amt_i, reg_amt_i,
                                carry_i, rimm_sel_i, rimm_val_i, rimm_rot_i,
                                result_o, carry_o});

    always_comb begin
        if (known && !rimm_sel_i && !src_reg_i && imm_amt_i == '0) begin
            if (kind_i == 2'd0)
                a_r5_lsl_zero_pass: assert (result_o == opd_i && carry_o == carry_i);
            if (kind_i == 2'd1)
                a_r6_lsr_zero_full: assert (result_o == '0 && carry_o == opd_i[DW-1]);
            if (kind_i == 2'd2)
                a_r7_asr_zero_fill: assert (result_o == {DW{opd_i[DW-1]}} && carry_o == opd_i[DW-1]);
            if (kind_i == 2'd3)
                a_r8_rrx: assert (result_o == {carry_i, opd_i[DW-1:1]} && carry_o == opd_i[0]);
        end
        if (known && !rimm_sel_i && src_reg_i && reg_amt_i[7:0] == 8'd0)
            a_r10_reg_zero_hold: assert (result_o == opd_i && carry_o == carry_i);
        if (known && rimm_sel_i && rimm_rot_i == '0)
            a_r14_rimm_no_rot: assert (result_o == {{(DW-IMW){1'b0}}, rimm_val_i} && carry_o == carry_i);
    end
endmodule

bind opshift_unit opshift_unit_chk #(.DW(DW), .IMW(IMW), .RFW(RFW)) u_chk (
    .opd_i      (opd_i),
    .kind_i     (kind_i),
    .src_reg_i  (src_reg_i),
    .imm_amt_i  (imm_amt_i),
    .reg_amt_i  (reg_amt_i),
    .carry_i    (carry_i),
    .rimm_sel_i (rimm_sel_i),
    .rimm_val_i (rimm_val_i),
    .rimm_rot_i (rimm_rot_i),
    .result_o   (result_o),
    .carry_o    (carry_o)
);

// File: tb/opshift_unit_bench.sv
module opshift_unit_bench;
    logic        clk = 1'b0;
    logic [31:0] opd;
    logic [1:0]  kind;
    logic        src_reg;
    logic [4:0]  imm_amt;
    logic [31:0] reg_amt;
    logic        cin;
    logic        rsel;
    logic [7:0]  rval;
    logic [3:0]  rrot;
    logic [31:0] res;
    logic        cout;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    opshift_unit u_opshift_unit (
        .opd_i (opd), .kind_i (kind), .src_reg_i (src_reg), .imm_amt_i (imm_amt),
        .reg_amt_i (reg_amt), .carry_i (cin), .rimm_sel_i (rsel),
        .rimm_val_i (rval), .rimm_rot_i (rrot), .result_o (res), .carry_o (cout)
    );

    // Reference: shift by an already-resolved amount n (>= 1) bit by bit.
    function automatic logic [32:0] ref_shift(input logic [31:0] x, input int k, input int n);
        logic [31:0] r;
        logic        c;
        int          m;
        r = '0;
        c = 1'b0;
        case (k)
            0: begin
                for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? x[i-n] : 1'b0;
                c = (32 - n >= 0 && 32 - n < 32) ? x[32-n] : 1'b0;
            end
            1: begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : 1'b0;
                c = (n - 1 < 32) ? x[n-1] : 1'b0;
            end
            2: begin
                m = (n > 32) ? 32 : n;
                for (int i = 0; i < 32; i++) r[i] = (i + m < 32) ? x[i+m] : x[31];
                c = x[m-1];
            end
            default: begin
                m = n % 32;
                if (m == 0) begin
                    r = x;
                    c = x[31];
                end else begin
                    for (int i = 0; i < 32; i++) r[i] = x[(i + m) % 32];
                    c = x[m-1];
                end
            end
        endcase
        return {c, r};
    endfunction

    task automatic check(input string tag, input logic [31:0] er, input logic ec);
        n_chk++;
        if (res !== er || cout !== ec) begin
            n_fail++;
            $display("FAIL %s: got result=%h carry=%b, expected result=%h carry=%b",
                     tag, res, cout, er, ec);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog: got no completion, expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    logic [31:0] ops [6];
    int          ramts [14];

    initial begin
        logic [32:0] e;
        ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE; ops[2] = 32'hDEAD_BEEF;
        ops[3] = 32'h0000_0000; ops[4] = 32'hFFFF_FFFF; ops[5] = 32'h1234_5678;
        ramts[0] = 0;  ramts[1] = 1;  ramts[2] = 5;   ramts[3] = 31; ramts[4] = 32;
        ramts[5] = 33; ramts[6] = 40; ramts[7] = 63;  ramts[8] = 64; ramts[9] = 96;
        ramts[10] = 128; ramts[11] = 200; ramts[12] = 255; ramts[13] = 17;

        opd = '0; kind = 2'd0; src_reg = 1'b0; imm_amt = '0; reg_amt = '0;
        cin = 1'b0; rsel = 1'b0; rval = '0; rrot = '0;
        @(negedge clk); #1;
        // initial state: left shift by 0 of zero
        check("R5 initial", 32'h0, 1'b0);

        // Immediate-field sweep: all kinds, all amounts
        for (int oi = 0; oi < 6; oi++)
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 32; a++)
                    for (int ci = 0; ci < 2; ci++) begin
                        @(negedge clk);
                        opd = ops[oi]; kind = 2'(k); src_reg = 1'b0;
                        imm_amt = 5'(a); cin = ci[0]; rsel = 1'b0;
                        reg_amt = 32'hFFFF_FF00 ^ ops[oi];
                        #1;
                        if (a != 0) begin
                            e = ref_shift(ops[oi], k, a);
                            check(k == 0 ? "R1" : k == 1 ? "R2" : k == 2 ? "R3" : "R4", e[31:0], e[32]);
                        end else if (k == 0) check("R5", ops[oi], ci[0]);
                        else if (k == 1) check("R6", 32'h0, ops[oi][31]);
                        else if (k == 2) check("R7", {32{ops[oi][31]}}, ops[oi][31]);
                        else check("R8", {ci[0], ops[oi][31:1]}, ops[oi][0]);
                    end

        // Register-amount sweep with junk in upper bits
        for (int oi = 0; oi < 6; oi++)
            for (int k = 0; k < 4; k++)
                for (int ri = 0; ri < 14; ri++)
                    for (int ji = 0; ji < 2; ji++) begin
                        @(negedge clk);
                        opd = ops[oi]; kind = 2'(k); src_reg = 1'b1; imm_amt = 5'd0;
                        cin = ji[0]; rsel = 1'b0;
                        reg_amt = {(ji == 0) ? 24'h000000 : 24'hA5C3FF, 8'(ramts[ri])};
                        #1;
                        if (ramts[ri] == 0) check("R10", ops[oi], ji[0]);
                        else begin
                            e = ref_shift(ops[oi], k, ramts[ri]);
                            if (ji == 1) check("R9", e[31:0], e[32]);
                            else if (ramts[ri] >= 32 && k < 2) check("R11", e[31:0], e[32]);
                            else if (ramts[ri] >= 32) check("R12", e[31:0], e[32]);
                            else check(k == 0 ? "R1" : k == 1 ? "R2" : k == 2 ? "R3" : "R4", e[31:0], e[32]);
                        end
                    end

        // Rotated immediate: all rotations
        for (int v = 0; v < 4; v++)
            for (int r = 0; r < 16; r++)
                for (int ci = 0; ci < 2; ci++) begin
                    logic [7:0]  iv;
                    logic [31:0] z;
                    logic [31:0] er;
                    iv = (v == 0) ? 8'h81 : (v == 1) ? 8'hFF : (v == 2) ? 8'h00 : 8'h3C;
                    z  = {24'h0, iv};
                    for (int i = 0; i < 32; i++) er[i] = z[(i + 2*r) % 32];
                    @(negedge clk);
                    rsel = 1'b1; rval = iv; rrot = 4'(r); cin = ci[0];
                    opd = ops[v]; kind = 2'(v); src_reg = v[0]; imm_amt = 5'(r); reg_amt = 32'(r);
                    #1;
                    check("R13", er, (r == 0) ? ci[0] : er[31]);
                    if (r == 0) check("R14 rot zero", er, ci[0]);
                    else check("R14 rot nonzero", er, er[31]);
                end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule